// File: doc/BRIEF.md
# Error Pin Pulse Formatter

This block turns internal error indications into the electrical form an error output pin needs. Each channel drives one pin. Software picks the channel's format at run time from four choices: a steady level, active high or active low, or a timed pulse, active high or active low. In the level formats the pin follows a level-condition input continuously. In the pulse formats a rising edge on an assert-event input fires a single pulse. The pulse length comes from an 8-bit width value that holds the desired cycle count minus one.

Cycles are counted on the block clock, which is the 32.768 MHz reference clock in the target system. The top holds `NUM_PINS` independent channels, two by default: one for the system error pin and one for the clock error pin. Each channel has its own format select and width value. The select and width registers, and the error sources, sit outside this block.

Top module: `errfmt_pins`

## Requirements
- R1: With format code 0 (level, active high) on a channel, its pin equals its condition input in the same cycle, with no clock edge in between.
- R2: With format code 1 (level, active low) on a channel, its pin equals the inverse of its condition input in the same cycle.
- R3: With format code 2 (pulse, active high) or 3 (pulse, active low), a rising edge of the event input makes the pin active for exactly width+1 clock cycles. The pulse starts with the first clock edge that samples the event high. Active is 1 for code 2 and 0 for code 3.
- R4: Rising edges of the event input while a pulse is running are ignored, and so is an event held high. The running pulse keeps its length and does not restart.
- R5: The width value is captured when a pulse starts. Changing it during the pulse does not change that pulse's length.
- R6: In a pulse format with no pulse running, the pin rests at the inactive level (0 for code 2, 1 for code 3) whatever the condition input does.
- R7: A change of format select takes effect in the same cycle and ends any running pulse; the pulse does not resume. An event edge that arrives in the same cycle as a format change is discarded.
- R8: Channels are independent. Channel i takes its format from select bits [2i+1:2i], its width from width bits [8i+7:8i], and its event and condition from bit i.
- R9: While reset is asserted, every pin behaves as format code 0 (pin equals condition) and any running pulse is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; pulse widths count its cycles |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_PINS | Assert event per channel; rising edge starts a pulse |
| cond_i | input | NUM_PINS | Level condition per channel, shown in level formats |
| fmt_sel_i | input | 2*NUM_PINS | Format select per channel, 2 bits each |
| width_i | input | WIDTH_W*NUM_PINS | Pulse width minus one per channel |
| pin_o | output | NUM_PINS | Formatted error pins |

## Verification
The level formats, the idle level in a pulse format, the effect of reset and the effect of a format change are all combinational. The bench samples those one time unit after it drives the inputs, with no clock edge between. A pulse begins at the first rising clock edge that sees the event high. The bench drives the event away from the edge and samples the pin shortly after each following rising edge. It counts the active samples over a window several cycles longer than width+1, so a pulse that is one cycle too long or too short shows up as a wrong count. Retrigger, width-change and abort stimuli are applied between samples inside that same window.

// File: rtl/errfmt_pkg.sv
package errfmt_pkg;

    typedef enum logic [1:0] {
        FMT_LVL_HI = 2'd0,
        FMT_LVL_LO = 2'd1,
        FMT_PUL_HI = 2'd2,
        FMT_PUL_LO = 2'd3
    } fmt_e;

    localparam int SEL_W = 2;

    function automatic logic is_pulse(input fmt_e f);
        return f[1];
    endfunction

    // Level the pin takes when nothing is being signalled.
    function automatic logic idle_level(input fmt_e f);
        return f[0];
    endfunction

endpackage

// File: rtl/errfmt_edge.sv
module errfmt_edge (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    output logic rise_o
);
    logic evt_q;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= 1'b0;
        else     evt_q <= evt_i;
    end

    assign rise_o = evt_i & ~evt_q;
endmodule

// File: rtl/errfmt_timer.sv
module errfmt_timer
    import errfmt_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  fmt_e               fmt_i,
    input  logic               evt_i,
    input  logic               rise_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               run_o
);
    fmt_e               fmt_q;
    logic               active;
    logic [WIDTH_W-1:0] cnt;
    logic [WIDTH_W-1:0] width_q;
    logic               chg;

    assign chg = (fmt_i != fmt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q   <= FMT_LVL_HI;
            active  <= 1'b0;
            cnt     <= '0;
            width_q <= '0;
        end else begin
            fmt_q <= fmt_i;
            if (chg) begin
                active <= 1'b0;
            end else if (active) begin
                if (cnt == '0) active <= 1'b0;
                else           cnt    <= cnt - 1'b1;
            end else if (rise_i && is_pulse(fmt_i)) begin
                active  <= 1'b1;
                cnt     <= width_i;
                width_q <= width_i;
            end
        end
    end

    assign run_o = active & ~chg & ~rst;

    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ($past(evt_i) && is_pulse($past(fmt_i)))); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> (cnt == WIDTH_W'($past(cnt) - 1'b1))); // R4
    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= width_q)); // R5
    AST_ABORT: assert property (@(posedge clk) disable iff (rst)
        chg |=> !active); // R7
endmodule

// File: rtl/errfmt_drive.sv
module errfmt_drive
    import errfmt_pkg::*;
(
    input  fmt_e fmt_i,
    input  logic run_i,
    input  logic cond_i,
    output logic pin_o
);
    logic asserted;

    always_comb begin
        if (is_pulse(fmt_i)) asserted = run_i;
        else                 asserted = cond_i;
        pin_o = asserted ^ idle_level(fmt_i);
    end
endmodule

// File: rtl/errfmt_pins.sv
module errfmt_pins
    import errfmt_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int WIDTH_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PINS-1:0]         evt_i,
    input  logic [NUM_PINS-1:0]         cond_i,
    input  logic [SEL_W*NUM_PINS-1:0]   fmt_sel_i,
    input  logic [WIDTH_W*NUM_PINS-1:0] width_i,
    output logic [NUM_PINS-1:0]         pin_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_ch
            fmt_e fmt_raw;
            fmt_e fmt_eff;
            logic rise;
            logic run;

            assign fmt_raw = fmt_e'(fmt_sel_i[SEL_W*gi +: SEL_W]);
            assign fmt_eff = rst ? FMT_LVL_HI : fmt_raw;

            errfmt_edge u_edge (
                .clk    (clk),
                .rst    (rst),
                .evt_i  (evt_i[gi]),
                .rise_o (rise)
            );

            errfmt_timer #(.WIDTH_W(WIDTH_W)) u_timer (
                .clk     (clk),
                .rst     (rst),
                .fmt_i   (fmt_raw),
                .evt_i   (evt_i[gi]),
                .rise_i  (rise),
                .width_i (width_i[WIDTH_W*gi +: WIDTH_W]),
                .run_o   (run)
            );

            errfmt_drive u_drive (
                .fmt_i  (fmt_eff),
                .run_i  (run),
                .cond_i (cond_i[gi]),
                .pin_o  (pin_o[gi])
            );

            AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
                !is_pulse(fmt_raw) |-> (pin_o[gi] == (cond_i[gi] ^ fmt_raw[0]))); // R1
            AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
                (is_pulse(fmt_raw) && !run) |-> (pin_o[gi] == fmt_raw[0])); // R6
        end
    endgenerate
endmodule

// File: tb/tb_errfmt_pins.sv
module tb_errfmt_pins;
    localparam int NP = 2;
    localparam int WW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     evt_i = '0;
    logic [NP-1:0]     cond_i = '0;
    logic [2*NP-1:0]   fmt_sel_i = '0;
    logic [WW*NP-1:0]  width_i = '0;
    logic [NP-1:0]     pin_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    errfmt_pins #(.NUM_PINS(NP), .WIDTH_W(WW)) dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .cond_i(cond_i),
        .fmt_sel_i(fmt_sel_i), .width_i(width_i), .pin_o(pin_o)
    );

    // {fmt0[1:0], cond0, fmt1[1:0], cond1, exp_pin1, exp_pin0}
    localparam logic [7:0] VEC [8] = '{
        8'b00_1_01_1_0_1,   // R1 R2
        8'b00_0_01_0_1_0,   // R1 R2
        8'b01_1_00_0_0_0,   // R1 R2
        8'b01_0_00_1_1_1,   // R1 R2
        8'b10_1_11_1_1_0,   // R6 idle, cond ignored
        8'b11_0_10_0_0_1,   // R6
        8'b10_0_00_1_1_0,   // R6 R8
        8'b11_1_01_0_1_1    // R6 R8
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input logic [1:0] f, input logic [WW-1:0] w);
        fmt_sel_i[2*ch +: 2] = f;
        width_i[WW*ch +: WW] = w;
    endtask

    // Drive a rising event on channel ch just after a falling edge, then count active
    // pin samples taken shortly after each following rising edge.
    // mode: 0 plain, 1 retrigger + width change mid-pulse
    task automatic run_pulse(input int ch, input logic act_lvl, input int win,
                             input int mode, output int cnt);
        cnt = 0;
        @(negedge clk);
        evt_i[ch] = 1'b1;
        for (int k = 0; k < win; k++) begin
            @(posedge clk);
            #1;
            if (pin_o[ch] == act_lvl) cnt++;
            if (mode == 1) begin
                if (k == 0) width_i[WW*ch +: WW] = 8'd200;
                if (k == 1) evt_i[ch] = 1'b0;
                if (k == 2) evt_i[ch] = 1'b1;
            end
        end
        evt_i[ch] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int c;
        logic [7:0] v;

        // R9: pins follow condition during reset
        set_ch(0, 2'd3, 8'd4);
        set_ch(1, 2'd1, 8'd4);
        cond_i = 2'b01;
        #1;
        check(pin_o == 2'b01, "R9 reset level-high", pin_o, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        set_ch(0, 2'd0, 8'd0);
        set_ch(1, 2'd0, 8'd0);
        cond_i = '0;
        repeat (2) @(negedge clk);

        // Vector table: level formats and idle pulse formats
        foreach (VEC[i]) begin
            v = VEC[i];
            fmt_sel_i[1:0] = v[7:6];
            cond_i[0]      = v[5];
            fmt_sel_i[3:2] = v[4:3];
            cond_i[1]      = v[2];
            #1;
            check(pin_o == v[1:0], "R1/R2/R6 vector", pin_o, v[1:0]);
            @(negedge clk);
        end

        // R3: width 0 -> one cycle, active high
        set_ch(0, 2'd2, 8'd0); cond_i = '0;
        set_ch(1, 2'd0, 8'd0);
        repeat (2) @(negedge clk);
        run_pulse(0, 1'b1, 6, 0, c);
        check(c == 1, "R3 width0 pulse length", c, 1);

        // R3: width 5, active low
        set_ch(0, 2'd3, 8'd5);
        repeat (2) @(negedge clk);
        run_pulse(0, 1'b0, 12, 0, c);
        check(c == 6, "R3 width5 low pulse length", c, 6);
        #1;
        check(pin_o[0] == 1'b1, "R6 idle high after low pulse", pin_o[0], 1);

        // R3: width 255 -> 256 cycles
        set_ch(0, 2'd2, 8'd255);
        repeat (2) @(negedge clk);
        run_pulse(0, 1'b1, 262, 0, c);
        check(c == 256, "R3 width255 pulse length", c, 256);

        // R4 R5: retrigger and width change during pulse
        set_ch(0, 2'd2, 8'd6);
        repeat (2) @(negedge clk);
        run_pulse(0, 1'b1, 14, 1, c);
        check(c == 7, "R4/R5 retrigger and width change ignored", c, 7);

        // R4: event held high does not restart
        set_ch(0, 2'd2, 8'd2);
        repeat (2) @(negedge clk);
        @(negedge clk); evt_i[0] = 1'b1;
        c = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            if (pin_o[0]) c++;
        end
        check(c == 3, "R4 held event single pulse", c, 3);
        @(negedge clk); evt_i[0] = 1'b0;
        @(negedge clk);

        // R7: abort mid-pulse, immediate effect, no resume
        set_ch(0, 2'd2, 8'd20);
        cond_i[0] = 1'b0;
        repeat (2) @(negedge clk);
        evt_i[0] = 1'b1;
        repeat (3) @(negedge clk);
        check(pin_o[0] == 1'b1, "R3 pulse running before abort", pin_o[0], 1);
        fmt_sel_i[1:0] = 2'd1;
        #1;
        check(pin_o[0] == 1'b1, "R7 level-low shown at once", pin_o[0], 1);
        @(negedge clk);
        fmt_sel_i[1:0] = 2'd2;
        #1;
        check(pin_o[0] == 1'b0, "R7 aborted pulse does not resume", pin_o[0], 0);
        repeat (3) @(negedge clk);
        check(pin_o[0] == 1'b0, "R7 still idle after abort", pin_o[0], 0);
        evt_i[0] = 1'b0;
        repeat (2) @(negedge clk);

        // R7: event edge in same cycle as format change is dropped
        set_ch(0, 2'd0, 8'd3);
        repeat (2) @(negedge clk);
        fmt_sel_i[1:0] = 2'd2;
        evt_i[0] = 1'b1;
        c = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            if (pin_o[0]) c++;
        end
        check(c == 0, "R7 edge on format change dropped", c, 0);
        @(negedge clk); evt_i[0] = 1'b0;
        @(negedge clk);

        // R8: channel 1 pulses, channel 0 untouched
        set_ch(0, 2'd0, 8'd9);
        cond_i[0] = 1'b1;
        set_ch(1, 2'd3, 8'd3);
        repeat (2) @(negedge clk);
        run_pulse(1, 1'b0, 9, 0, c);
        check(c == 4, "R8 channel1 own width", c, 4);
        check(pin_o[0] == 1'b1, "R8 channel0 unaffected", pin_o[0], 1);

        // R9: reset clears a running pulse
        set_ch(0, 2'd2, 8'd30);
        cond_i = '0;
        repeat (2) @(negedge clk);
        evt_i[0] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        cond_i[0] = 1'b0;
        #1;
        check(pin_o[0] == 1'b0, "R9 reset shows condition", pin_o[0], 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        evt_i[0] = 1'b0;
        repeat (2) @(negedge clk);
        check(pin_o[0] == 1'b0, "R9 pulse cleared by reset", pin_o[0], 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule